// File: doc/BRIEF.md
# Partially Tagged Branch and Jump Predictor

This block sits in the fetch stage. Each cycle it looks up the instruction-bus transfer address and decides whether the next fetch should go to a predicted target. It holds two small target tables. One serves conditional branches and works with a table of 2-bit saturating history counters. The other serves unconditional jumps and carries a valid bit for each row. Both tables pick a row from the same address bits. A row stores only a short slice of the address as its tag, so unrelated addresses can alias onto a stored entry. Such false hits are accepted and are left for later pipeline stages to correct.

The resolving stage trains the tables through an update port. It supplies the instruction address, the signed target offset, the resolved direction and the instruction kind. A prediction is only allowed while the downstream prediction buffer reports a free slot. The result is registered. The predicted flag, the target and an alignment flag appear one cycle after the address is presented. A target that is not word aligned costs the fetch one extra bubble, so the alignment flag lets the fetch logic account for it.

Top module: `bj_fetch_predictor`

## Requirements
- R1: While reset is high, and at the first clock after it, pred_hit, pred_target and pred_unaligned are all 0. Reset clears every jump valid bit and sets every history counter to 1, so no address is predicted before an update.
- R2: The row index is fetch_addr[5:2] and the tag is fetch_addr[11:6] (SHARE=20). Address bits [1:0] and bits [31:12] take no part in a hit, so an address that differs from a trained one only in those bits also hits.
- R3: A conditional branch is predicted only when its tag matches and its 2-bit counter is at least 2. A branch update with upd_taken=1 increments the counter and one with upd_taken=0 decrements it. The counter saturates at 3 and at 0.
- R4: The target is fetch_addr plus a sign-extended byte offset. upd_off carries the offset in halfwords (byte offset bits [20:1]). A branch row keeps only the low 12 halfword bits, which gives a 13-bit signed byte offset. A jump row keeps all 20 bits, which gives a 21-bit signed byte offset. The sum wraps modulo 2^32.
- R5: An update with upd_jump=1 writes the jump row and sets its valid bit, whatever upd_taken is. A valid jump row predicts on a tag match without consulting any counter, and only reset clears its valid bit.
- R6: When the branch and jump lookups both hit, the jump target is used.
- R7: When slot_free is 0 in the cycle the address is sampled, pred_hit is 0 in the next cycle.
- R8: Outputs change one clock after the sampled fetch_addr and slot_free. A lookup in the same cycle as an update to the same row still sees the row's old contents.
- R9: pred_unaligned equals bit 1 of the target when pred_hit is 1. When pred_hit is 0, pred_target and pred_unaligned are 0.
- R10: A fetch address whose tag bits differ from the stored tag of its row produces no prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 32 | Transfer address being looked up |
| slot_free | input | 1 | Prediction buffer can accept a target |
| upd_vld | input | 1 | Update strobe from the resolving stage |
| upd_addr | input | 32 | Address of the resolved instruction |
| upd_off | input | 20 | Signed target offset in halfwords |
| upd_taken | input | 1 | Resolved direction of a conditional branch |
| upd_jump | input | 1 | 1 for an unconditional jump, 0 for a branch |
| pred_hit | output | 1 | A prediction is made |
| pred_target | output | 32 | Predicted next fetch address |
| pred_unaligned | output | 1 | Target is not word aligned |

## Verification
The branch path is driven with runs of taken and not-taken updates that are longer than the counter range. These runs show the saturation at the threshold, and a counter that wraps would predict where the correct one does not. Aliased addresses differ from a trained address in their upper or lowest bits, while another address keeps the same row but changes a tag bit. Together they separate the tag slice from the index and from the ignored bits. Offsets at the extremes of both field widths, including one that exceeds the 13-bit branch range, show the sign extension and the truncation. The remaining tests cover a jump and a branch sharing a row, a lookup made while the prediction buffer is full, and an update and a lookup to the same row in the same cycle.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MIN   = 2'd0;
  localparam ctr_t CTR_WEAK  = 2'd1;
  localparam ctr_t CTR_TAKE  = 2'd2;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam int unsigned LOW_SKIP = 2;
endpackage

// File: rtl/ptp_sat_counters.sv
module ptp_sat_counters #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import ptp_pkg::*;
  localparam int unsigned ROWS = 1 << IDX_W;

  ctr_t ctr_q [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) ctr_q[i] <= CTR_WEAK;
    end else if (wr_en) begin
      if (wr_taken && ctr_q[wr_idx] != CTR_MAX)
        ctr_q[wr_idx] <= ctr_q[wr_idx] + 2'd1;
      else if (!wr_taken && ctr_q[wr_idx] != CTR_MIN)
        ctr_q[wr_idx] <= ctr_q[wr_idx] - 2'd1;
    end
  end

  assign rd_taken = (ctr_q[rd_idx] >= CTR_TAKE);

  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX); // R3
  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN); // R3
endmodule

// File: rtl/ptp_target_table.sv
module ptp_target_table #(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned TAG_W     = 6,
  parameter int unsigned OFF_W     = 12,
  parameter bit          USE_VALID = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [OFF_W-1:0] rd_off,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_off
);
  localparam int unsigned ROWS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [ROWS];
  logic [OFF_W-1:0] off_mem [ROWS];
  logic [ROWS-1:0]  row_ok;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      off_mem[wr_idx] <= wr_off;
    end
  end

  generate
    if (USE_VALID) begin : g_valid
      logic [ROWS-1:0] vld_q;
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
      end
      assign row_ok = vld_q;
      for (genvar r = 0; r < ROWS; r++) begin : g_chk
        AST_VLD_STICKY: assert property (@(posedge clk) disable iff (rst)
          vld_q[r] |=> vld_q[r]); // R5
      end
    end else begin : g_novalid
      assign row_ok = '1;
    end
  endgenerate

  assign rd_hit = row_ok[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_off = off_mem[rd_idx];
endmodule

// File: rtl/bj_fetch_predictor.sv
module bj_fetch_predictor #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned SHARE     = 20,
  parameter int unsigned BR_OFF_W  = 13,
  parameter int unsigned JMP_OFF_W = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 slot_free,
  input  logic                 upd_vld,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic [JMP_OFF_W-2:0] upd_off,
  input  logic                 upd_taken,
  input  logic                 upd_jump,
  output logic                 pred_hit,
  output logic [ADDR_W-1:0]    pred_target,
  output logic                 pred_unaligned
);
  import ptp_pkg::*;
  localparam int unsigned IDX_LSB = LOW_SKIP;
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - SHARE - IDX_W - LOW_SKIP;
  localparam int unsigned BR_FW   = BR_OFF_W - 1;
  localparam int unsigned JMP_FW  = JMP_OFF_W - 1;

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              br_tag_hit, br_strong, jmp_hit;
  logic [BR_FW-1:0]  br_off;
  logic [JMP_FW-1:0] jmp_off;
  logic [ADDR_W-1:0] off_ext, sum;
  logic              any_hit;

  assign f_idx = fetch_addr[IDX_LSB +: IDX_W];
  assign f_tag = fetch_addr[TAG_LSB +: TAG_W];
  assign u_idx = upd_addr[IDX_LSB +: IDX_W];
  assign u_tag = upd_addr[TAG_LSB +: TAG_W];

  logic unused_upd_bits;
  assign unused_upd_bits = ^{upd_addr[ADDR_W-1:TAG_LSB+TAG_W], upd_addr[IDX_LSB-1:0]};

  ptp_target_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(BR_FW), .USE_VALID(1'b0)) u_btb (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_tag(f_tag), .rd_hit(br_tag_hit), .rd_off(br_off),
    .wr_en(upd_vld && !upd_jump), .wr_idx(u_idx), .wr_tag(u_tag), .wr_off(upd_off[BR_FW-1:0])
  );

  ptp_sat_counters #(.IDX_W(IDX_W)) u_bht (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_taken(br_strong),
    .wr_en(upd_vld && !upd_jump), .wr_idx(u_idx), .wr_taken(upd_taken)
  );

  ptp_target_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(JMP_FW), .USE_VALID(1'b1)) u_jtb (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_tag(f_tag), .rd_hit(jmp_hit), .rd_off(jmp_off),
    .wr_en(upd_vld && upd_jump), .wr_idx(u_idx), .wr_tag(u_tag), .wr_off(upd_off)
  );

  always_comb begin
    if (jmp_hit)
      off_ext = {{(ADDR_W-JMP_OFF_W){jmp_off[JMP_FW-1]}}, jmp_off, 1'b0};
    else
      off_ext = {{(ADDR_W-BR_OFF_W){br_off[BR_FW-1]}}, br_off, 1'b0};
    sum     = fetch_addr + off_ext;
    any_hit = slot_free && (jmp_hit || (br_tag_hit && br_strong));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_hit       <= 1'b0;
      pred_target    <= '0;
      pred_unaligned <= 1'b0;
    end else begin
      pred_hit       <= any_hit;
      pred_target    <= any_hit ? sum : '0;
      pred_unaligned <= any_hit && sum[1];
    end
  end

  AST_NO_ROOM_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    !slot_free |=> !pred_hit); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!pred_hit && pred_target == '0)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_target == '0 && !pred_unaligned)); // R9
endmodule

// File: tb/sim_bj_fetch_predictor.sv
module sim_bj_fetch_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] fetch_addr;
  logic        slot_free;
  logic        upd_vld;
  logic [31:0] upd_addr;
  logic [19:0] upd_off;
  logic        upd_taken;
  logic        upd_jump;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        pred_unaligned;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bj_fetch_predictor u0 (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .slot_free(slot_free),
    .upd_vld(upd_vld), .upd_addr(upd_addr), .upd_off(upd_off),
    .upd_taken(upd_taken), .upd_jump(upd_jump),
    .pred_hit(pred_hit), .pred_target(pred_target), .pred_unaligned(pred_unaligned)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [31:0] a, input int boff, input bit taken, input bit jump);
    logic [31:0] hw;
    hw = 32'(boff >>> 1);
    @(negedge clk);
    upd_vld = 1'b1; upd_addr = a; upd_off = hw[19:0]; upd_taken = taken; upd_jump = jump;
    @(posedge clk);
    @(negedge clk);
    upd_vld = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input bit room, input bit exp_hit,
                      input int boff, input string req);
    logic [31:0] t;
    t = exp_hit ? a + 32'(boff) : 32'd0;
    @(negedge clk);
    fetch_addr = a; slot_free = room;
    @(posedge clk);
    @(negedge clk);
    check({req, " hit"}, {31'd0, pred_hit}, {31'd0, exp_hit});
    check({req, " target"}, pred_target, t);
    check({req, " unaligned"}, {31'd0, pred_unaligned}, {31'd0, exp_hit & t[1]});
  endtask

  task automatic t_reset;
    check("R1 reset hit", {31'd0, pred_hit}, 32'd0);
    check("R1 reset target", pred_target, 32'd0);
    look(32'h0000_0910, 1'b1, 1'b0, 0, "R1 untrained");
    look(32'h0000_2040, 1'b1, 1'b0, 0, "R1 untrained jump row");
  endtask

  task automatic t_branch;
    upd(32'h910, -256, 1'b1, 1'b0);                 // counter 1 -> 2
    look(32'h910, 1'b1, 1'b1, -256, "R3 R4 branch taken");
    upd(32'h910, -256, 1'b0, 1'b0);                 // 2 -> 1
    look(32'h910, 1'b1, 1'b0, 0, "R3 weak not taken");
    for (int i = 0; i < 4; i++) upd(32'h910, -256, 1'b1, 1'b0); // saturate at 3
    upd(32'h910, -256, 1'b0, 1'b0);
    upd(32'h910, -256, 1'b0, 1'b0);                 // 3 -> 1
    look(32'h910, 1'b1, 1'b0, 0, "R3 high saturation");
    for (int i = 0; i < 3; i++) upd(32'h910, -256, 1'b0, 1'b0); // saturate at 0
    upd(32'h910, -256, 1'b1, 1'b0);                 // 0 -> 1
    look(32'h910, 1'b1, 1'b0, 0, "R3 low saturation");
    upd(32'h910, -256, 1'b1, 1'b0);                 // 1 -> 2
    look(32'h910, 1'b1, 1'b1, -256, "R3 threshold");
  endtask

  task automatic t_alias;
    look(32'h0000_1910, 1'b1, 1'b1, -256, "R2 upper bits alias");
    look(32'hABCD_E910, 1'b1, 1'b1, -256, "R2 high bits alias");
    look(32'h0000_0913, 1'b1, 1'b1, -256, "R2 R9 low bits unaligned");
    look(32'h0000_0950, 1'b1, 1'b0, 0, "R10 tag mismatch");
  endtask

  task automatic t_offsets;
    upd(32'h4008, 32'h1000, 1'b1, 1'b0);            // exceeds 13-bit field
    look(32'h4008, 1'b1, 1'b1, -4096, "R4 branch offset width");
    upd(32'h2040, -1048576, 1'b0, 1'b0 | 1'b1);
    look(32'h2040, 1'b1, 1'b1, -1048576, "R5 R4 jump min offset");
    upd(32'h2040, 32'hFFFFE, 1'b0, 1'b1);
    look(32'h2040, 1'b1, 1'b1, 32'hFFFFE, "R4 R9 jump max offset");
  endtask

  task automatic t_priority;
    upd(32'h910, 32'h400, 1'b0, 1'b1);
    look(32'h910, 1'b1, 1'b1, 32'h400, "R6 jump over branch");
  endtask

  task automatic t_room;
    look(32'h910, 1'b0, 1'b0, 0, "R7 buffer full");
    look(32'h910, 1'b1, 1'b1, 32'h400, "R7 buffer free again");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_vld = 1'b1; upd_addr = 32'h3004; upd_off = 20'd4; upd_taken = 1'b0; upd_jump = 1'b1;
    fetch_addr = 32'h3004; slot_free = 1'b1;
    @(posedge clk);
    @(negedge clk);
    upd_vld = 1'b0;
    check("R8 old contents on same-cycle write", {31'd0, pred_hit}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 new contents next cycle hit", {31'd0, pred_hit}, 32'd1);
    check("R8 new contents next cycle target", pred_target, 32'h300C);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fetch_addr = '0; slot_free = 1'b1;
    upd_vld = 1'b0; upd_addr = '0; upd_off = '0; upd_taken = 1'b0; upd_jump = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset hit", {31'd0, pred_hit}, 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    t_reset();
    t_branch();
    t_alias();
    t_offsets();
    t_priority();
    t_room();
    t_same_cycle();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule